// File: doc/BRIEF.md
# Divided Countdown Timer

This block is a down-counting timer whose count advances once per tick of a programmable prescaler. Software loads a start value through a small register port; the value is copied into a live count register, which then falls by one on every divided tick. When the count runs out, the timer posts an interrupt request that carries a programmed vector, unless its mask bit is set. In periodic mode the count reloads from the start value and keeps running. In one-shot mode it rests at zero.

The request is held on a simple request/acknowledge pair toward the interrupt core. A read-only pending flag in the control entry mirrors that request until the core accepts it. The prescaler divides by 1 or by a power of two up to 128. It is selected by a 4-bit code whose encoding is not contiguous. Writing a new code restarts the prescaler phase.

Top module: `divtimer`

## Requirements
- R1: After reset, irq_req is 0, the current count (address 2) reads 0, the control entry (address 0) reads 0x0001_0000 (masked, one-shot, vector 0) and the divide register (address 3) reads 0.
- R2: A write to the start-value register (address 1) stores the value there and copies it into the current count (address 2). The copy is visible on the clock edge of the write.
- R3: With divisor D, the current count decreases by one every D cycles. The first decrement comes D edges after the loading write, and the count runs out N*D edges after loading N.
- R4: The divide code in address 3 bits [3:0] selects the divisor: 0000→2, 0001→4, 0010→8, 0011→16, 1000→32, 1001→64, 1010→128, 1011→1. Bit 2 has no effect, so 0100 divides by 2 and 1111 divides by 1.
- R5: In one-shot mode (control bit 17 = 0), running out raises irq_req on the edge where the count reaches 0. The count then stays at 0 and no further request follows.
- R6: In periodic mode (control bit 17 = 1), running out raises irq_req and reloads the start value in the same edge, so requests repeat every N*D cycles.
- R7: While the mask bit (control bit 16) is 1, running out raises no request and the counting continues.
- R8: irq_vec equals the control vector (bits [7:0]). Control bit 12 reads 1 exactly while irq_req is 1. A request stays up until irq_ack is sampled high, and it drops on that edge.
- R9: Writes to the current count (address 2) are ignored.
- R10: Writing 0 as the start value stops the timer. The count reads 0 and no request is raised.
- R11: Writing the divide register restarts the prescaler phase. The next decrement comes D edges after that write.
- R12: Control bit 12 is read-only, and writing 1 to it raises no request and does not set it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address (0 control, 1 start value, 2 current count, 3 divide) |
| wr_data | input | 32 | Write data |
| rd_addr | input | 2 | Read address, same map as writes |
| rd_data | output | 32 | Combinational read data |
| irq_req | output | 1 | Interrupt request, held until acknowledged |
| irq_vec | output | 8 | Vector carried with the request |
| irq_ack | input | 1 | Acceptance of the request by the interrupt core |

## Verification
The bench walks every divide code, including the two with bit 2 set. A decoder that honoured bit 2, or that shifted the upper group by one place, would show its first decrement in the wrong cycle. It checks the exact cycle in which the request rises and the one before, which catches an off-by-one between loading N and firing after N ticks. It re-writes the divide code mid-interval to catch a prescaler that keeps its old phase. It also confirms that a masked or periodic timer never leaves the count stuck at 0 or fires while masked. Writes to the current count and to the pending bit are checked at the read port, because a design that let them through would corrupt the countdown or fake a request.

// File: rtl/divtimer_pkg.sv
package divtimer_pkg;

   localparam int CODE_W       = 4;
   localparam int MAX_SHIFT    = 7;
   localparam int PRE_W        = MAX_SHIFT;
   localparam int ENT_PEND_BIT = 12;
   localparam int ENT_MASK_BIT = 16;
   localparam int ENT_MODE_BIT = 17;

   typedef enum logic [1:0] {
      ADDR_ENTRY = 2'd0,
      ADDR_START = 2'd1,
      ADDR_LIVE  = 2'd2,
      ADDR_DIV   = 2'd3
   } reg_addr_e;

   // Power-of-two exponent for a divide code; bit 2 plays no part.
   function automatic logic [2:0] div_shift(input logic [1:0] low, input logic top);
      logic [2:0] idx;
      idx = {top, low};
      return (idx == 3'd7) ? 3'd0 : idx + 3'd1;
   endfunction

endpackage

// File: rtl/divtimer_prescale.sv
module divtimer_prescale
   import divtimer_pkg::*;
#(
   parameter int PW = PRE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   input  logic              restart,
   input  logic [CODE_W-1:0] code,
   output logic              tick
);

   generate
      if (PW < MAX_SHIFT) begin : g_bad_width
         $error("prescaler width too small for divide-by-128");
      end
   endgenerate

   logic [2:0]    shift;
   logic [PW-1:0] limit;
   logic [PW-1:0] phase_q;
   logic          unused_ok;

   assign unused_ok = code[2];
   assign shift     = div_shift(code[1:0], code[3]);
   assign limit     = PW'((32'd1 << shift) - 32'd1);
   assign tick      = run && (phase_q == limit);

   always_ff @(posedge clk) begin
      if (!rst_n || restart || !run || tick) begin
         phase_q <= '0;
      end else begin
         phase_q <= phase_q + 1'b1;
      end
   end

endmodule

// File: rtl/divtimer_counter.sv
module divtimer_counter #(
   parameter int CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic             tick,
   input  logic             periodic,
   output logic [CNT_W-1:0] cur,
   output logic [CNT_W-1:0] start,
   output logic             run,
   output logic             expire
);

   generate
      if (CNT_W < 2) begin : g_bad_cnt
         $error("count width must be at least 2");
      end
   endgenerate

   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   assign run    = (cur != '0);
   assign expire = tick && (cur == ONE) && !load;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cur   <= '0;
         start <= '0;
      end else if (load) begin
         cur   <= load_val;
         start <= load_val;
      end else if (tick && run) begin
         if (cur == ONE) begin
            cur <= periodic ? start : '0;
         end else begin
            cur <= cur - ONE;
         end
      end
   end

endmodule

// File: rtl/divtimer_request.sv
module divtimer_request (
   input  logic clk,
   input  logic rst_n,
   input  logic fire,
   input  logic ack,
   output logic pend
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend <= 1'b0;
      end else if (fire) begin
         pend <= 1'b1;
      end else if (ack) begin
         pend <= 1'b0;
      end
   end

endmodule

// File: rtl/divtimer.sv
module divtimer
   import divtimer_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int CNT_W  = 32,
   parameter int VEC_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [1:0]        wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [1:0]        rd_addr,
   output logic [DATA_W-1:0] rd_data,
   output logic              irq_req,
   output logic [VEC_W-1:0]  irq_vec,
   input  logic              irq_ack
);

   generate
      if (DATA_W <= ENT_MODE_BIT) begin : g_bad_data
         $error("data width cannot hold the control entry");
      end
      if (CNT_W > DATA_W) begin : g_bad_cnt
         $error("count wider than the data port");
      end
      if (VEC_W > ENT_PEND_BIT) begin : g_bad_vec
         $error("vector overlaps the pending bit");
      end
   endgenerate

   logic [VEC_W-1:0]  vec_q;
   logic              mask_q;
   logic              mode_q;
   logic [CODE_W-1:0] code_q;
   logic              wr_entry, wr_start, wr_div;
   logic              tick, run, expire, pend;
   logic [CNT_W-1:0]  cur_q, start_q;
   logic              unused_ok;

   assign unused_ok = ^wr_data;
   assign wr_entry  = wr_en && (wr_addr == ADDR_ENTRY);
   assign wr_start  = wr_en && (wr_addr == ADDR_START);
   assign wr_div    = wr_en && (wr_addr == ADDR_DIV);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vec_q  <= '0;
         mask_q <= 1'b1;
         mode_q <= 1'b0;
         code_q <= '0;
      end else begin
         if (wr_entry) begin
            vec_q  <= wr_data[VEC_W-1:0];
            mask_q <= wr_data[ENT_MASK_BIT];
            mode_q <= wr_data[ENT_MODE_BIT];
         end
         if (wr_div) begin
            code_q <= wr_data[CODE_W-1:0];
         end
      end
   end

   divtimer_prescale u_pre (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (run),
      .restart (wr_start || wr_div),
      .code    (code_q),
      .tick    (tick)
   );

   divtimer_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (wr_start),
      .load_val (wr_data[CNT_W-1:0]),
      .tick     (tick),
      .periodic (mode_q),
      .cur      (cur_q),
      .start    (start_q),
      .run      (run),
      .expire   (expire)
   );

   divtimer_request u_req (
      .clk   (clk),
      .rst_n (rst_n),
      .fire  (expire && !mask_q),
      .ack   (irq_ack),
      .pend  (pend)
   );

   assign irq_req = pend;
   assign irq_vec = vec_q;

   always_comb begin
      rd_data = '0;
      case (rd_addr)
         ADDR_ENTRY: begin
            rd_data[VEC_W-1:0]   = vec_q;
            rd_data[ENT_PEND_BIT] = pend;
            rd_data[ENT_MASK_BIT] = mask_q;
            rd_data[ENT_MODE_BIT] = mode_q;
         end
         ADDR_START: rd_data[CNT_W-1:0]  = start_q;
         ADDR_LIVE:  rd_data[CNT_W-1:0]  = cur_q;
         default:    rd_data[CODE_W-1:0] = code_q;
      endcase
   end

endmodule

// File: rtl/divtimer_chk.sv
module divtimer_chk
   import divtimer_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int CNT_W  = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic [1:0]        wr_addr,
   input logic [DATA_W-1:0] wr_data,
   input logic              irq_req,
   input logic              irq_ack,
   input logic              mask_q,
   input logic [CNT_W-1:0]  cur_q
);

   logic ld;
   assign ld = wr_en && (wr_addr == ADDR_START);

   // R2
   load_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ld |=> (cur_q == $past(wr_data[CNT_W-1:0])));

   // R5
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cur_q == '0 && !ld) |=> (cur_q == '0));

   // R7
   masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!irq_req && mask_q) |=> !irq_req);

   // R8
   pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_req && !irq_ack) |=> irq_req);

   // R9
   step_by_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cur_q > CNT_W'(1) && !ld) |=>
         (cur_q == $past(cur_q) || cur_q == $past(cur_q) - CNT_W'(1)));

endmodule

bind divtimer divtimer_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .wr_en   (wr_en),
   .wr_addr (wr_addr),
   .wr_data (wr_data),
   .irq_req (irq_req),
   .irq_ack (irq_ack),
   .mask_q  (mask_q),
   .cur_q   (cur_q)
);

// File: tb/divtimer_bench.sv
`timescale 1ns/1ps
module divtimer_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [1:0]  wr_addr = '0;
   logic [31:0] wr_data = '0;
   logic [1:0]  rd_addr = '0;
   logic [31:0] rd_data;
   logic        irq_req;
   logic [7:0]  irq_vec;
   logic        irq_ack = 1'b0;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   divtimer u_divtimer (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
      .irq_req(irq_req), .irq_vec(irq_vec), .irq_ack(irq_ack)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic waitc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(input logic [1:0] a, input logic [31:0] d);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(posedge clk);
      @(negedge clk);
      wr_en = 1'b0; wr_data = '0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [31:0] d);
      rd_addr = a;
      #0.5;
      d = rd_data;
   endtask

   task automatic ack();
      irq_ack = 1'b1;
      @(posedge clk);
      @(negedge clk);
      irq_ack = 1'b0;
   endtask

   task automatic t_reset();
      logic [31:0] d;
      chk("R1 irq_req", {31'b0, irq_req}, 32'd0);
      rd(2'd2, d); chk("R1 current", d, 32'd0);
      rd(2'd0, d); chk("R1 control", d, 32'h0001_0000);
      rd(2'd3, d); chk("R1 divide", d, 32'd0);
   endtask

   task automatic t_oneshot();
      logic [31:0] d;
      wr(2'd0, 32'h0000_0040);
      wr(2'd3, 32'h0000_000B);
      wr(2'd1, 32'd5);
      rd(2'd2, d); chk("R2 current after load", d, 32'd5);
      rd(2'd1, d); chk("R2 start readback", d, 32'd5);
      waitc(1);
      rd(2'd2, d); chk("R3 first decrement", d, 32'd4);
      waitc(3);
      chk("R5 no early request", {31'b0, irq_req}, 32'd0);
      waitc(1);
      chk("R5 request at expiry", {31'b0, irq_req}, 32'd1);
      chk("R8 vector", {24'b0, irq_vec}, 32'h40);
      rd(2'd0, d); chk("R8 pending bit set", {31'b0, d[12]}, 32'd1);
      waitc(3);
      chk("R8 held without ack", {31'b0, irq_req}, 32'd1);
      ack();
      chk("R8 dropped on ack", {31'b0, irq_req}, 32'd0);
      rd(2'd0, d); chk("R8 pending bit clear", {31'b0, d[12]}, 32'd0);
      waitc(20);
      chk("R5 no second request", {31'b0, irq_req}, 32'd0);
      rd(2'd2, d); chk("R5 count rests at 0", d, 32'd0);
   endtask

   task automatic t_divide(input logic [3:0] code, input int dv, input string req);
      logic [31:0] d;
      wr(2'd3, {28'b0, code});
      wr(2'd1, 32'd3);
      waitc(dv - 1);
      rd(2'd2, d); chk({req, " hold before tick"}, d, 32'd3);
      waitc(1);
      rd(2'd2, d); chk({req, " decrement at D"}, d, 32'd2);
      waitc(2 * dv - 1);
      chk({req, " no request at 3D-1"}, {31'b0, irq_req}, 32'd0);
      waitc(1);
      chk({req, " request at 3D"}, {31'b0, irq_req}, 32'd1);
      ack();
   endtask

   task automatic t_periodic();
      logic [31:0] d;
      wr(2'd3, 32'h0000_000B);
      wr(2'd0, 32'h0002_0055);
      wr(2'd1, 32'd4);
      waitc(3);
      chk("R6 no early request", {31'b0, irq_req}, 32'd0);
      waitc(1);
      chk("R6 first request", {31'b0, irq_req}, 32'd1);
      chk("R6 vector", {24'b0, irq_vec}, 32'h55);
      rd(2'd2, d); chk("R6 reload", d, 32'd4);
      ack();
      waitc(2);
      chk("R6 quiet between", {31'b0, irq_req}, 32'd0);
      waitc(1);
      chk("R6 second request", {31'b0, irq_req}, 32'd1);
      ack();
      wr(2'd1, 32'd0);
      rd(2'd2, d); chk("R10 stopped count", d, 32'd0);
      waitc(30);
      chk("R10 no request", {31'b0, irq_req}, 32'd0);
   endtask

   task automatic t_mask();
      logic [31:0] d;
      wr(2'd0, 32'h0003_0066);
      wr(2'd1, 32'd3);
      waitc(20);
      chk("R7 masked no request", {31'b0, irq_req}, 32'd0);
      rd(2'd2, d); chk("R7 still counting", {31'b0, d != 0}, 32'd1);
      wr(2'd1, 32'd0);
      wr(2'd0, 32'h0000_0066);
   endtask

   task automatic t_curwrite();
      logic [31:0] d;
      wr(2'd3, 32'h0000_0003);
      wr(2'd1, 32'd100);
      wr(2'd2, 32'h0000_DEAD);
      rd(2'd2, d); chk("R9 current unchanged", d, 32'd100);
      rd(2'd1, d); chk("R9 start unchanged", d, 32'd100);
      wr(2'd1, 32'd0);
   endtask

   task automatic t_phase();
      logic [31:0] d;
      wr(2'd3, 32'h0000_0002);
      wr(2'd1, 32'd2);
      waitc(5);
      wr(2'd3, 32'h0000_0002);
      waitc(7);
      rd(2'd2, d); chk("R11 phase restarted", d, 32'd2);
      waitc(1);
      rd(2'd2, d); chk("R11 tick D after rewrite", d, 32'd1);
      wr(2'd1, 32'd0);
   endtask

   task automatic t_pend_ro();
      logic [31:0] d;
      wr(2'd0, 32'h0000_1077);
      rd(2'd0, d); chk("R12 pending bit ignored", d, 32'h0000_0077);
      chk("R12 no request", {31'b0, irq_req}, 32'd0);
   endtask

   initial begin
      waitc(4);
      rst_n = 1'b1;
      waitc(1);
      t_reset();
      t_oneshot();
      wr(2'd0, 32'h0000_0011);
      t_divide(4'b1011, 1,   "R4 code 1011");
      t_divide(4'b0000, 2,   "R3 code 0000");
      t_divide(4'b0001, 4,   "R3 code 0001");
      t_divide(4'b0010, 8,   "R3 code 0010");
      t_divide(4'b0011, 16,  "R3 code 0011");
      t_divide(4'b1000, 32,  "R3 code 1000");
      t_divide(4'b1001, 64,  "R3 code 1001");
      t_divide(4'b1010, 128, "R3 code 1010");
      t_divide(4'b0100, 2,   "R4 code 0100");
      t_divide(4'b1111, 1,   "R4 code 1111");
      t_periodic();
      t_mask();
      t_curwrite();
      t_phase();
      t_pend_ro();
      if (!done) begin
         done = 1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1;
         checks++;
         errors++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule